// File: doc/BRIEF.md
# Access-Triggered Interrupt Gate

This block sits on the bus side of a simple I/O-port card and decides whether the card raises its single interrupt request. It has no status register, and it uses no data values. Software controls the interrupt only through the kind of bus cycle it issues at two fixed offsets. A write cycle to the enable offset turns the interrupt on. A read cycle from that same offset turns it off. Any cycle, read or write, to the clear offset discards the pending event.

Internal event lines feed a pending latch, which is set on each rising edge of any event line. The request output is high only while the enable and the pending latch are both set. A host that sees the request must assume the request came from this card. Each access is counted once, when its strobe rises, so a strobe held high across many clocks acts once. An event that arrives in the same cycle as a clear is kept.

Top module: `irq_gate_top`

## Requirements
- R1: While reset is asserted and right after it, the enable and the pending latch are clear and `irq_req` is low.
- R2: A write access (rising edge of `bus_cs & bus_wr`) with `bus_addr` equal to 0xB sets the enable.
- R3: A read access (rising edge of `bus_cs & bus_rd`) with `bus_addr` equal to 0xB clears the enable.
- R4: A read or write access with `bus_addr` equal to 0xF clears the pending latch.
- R5: A rising edge on any bit of `evt_in` sets the pending latch. An event line that stays high does not set it again after a clear.
- R6: `irq_req` is high exactly when the enable and the pending latch are both set. Both are registered, so `irq_req` follows an access or an event by one clock.
- R7: An access acts only in the cycle its strobe rises. A strobe held high for further cycles has no further effect.
- R8: If a clear access and an event edge fall in the same cycle, the pending latch ends up set.
- R9: While `bus_cs & bus_rd` is high with `bus_addr` equal to 0xB or 0xF, `bus_rd_claim` is high and `bus_rdata` is 0x00. At every other address, and whenever there is no chip-selected read, `bus_rd_claim` is low.
- R10: Strobes with `bus_cs` low, and accesses to any offset other than 0xB and 0xF, leave the enable and the pending latch unchanged.
- R11: If a read and a write access to 0xB rise in the same cycle, the enable ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | ADDR_W (4) | Register offset |
| evt_in | input | NUM_EVT (3) | Internal event lines, edge sensitive |
| bus_rdata | output | DATA_W (8) | Read data, always 0x00 |
| bus_rd_claim | output | 1 | High while this block answers a read |
| irq_req | output | 1 | Interrupt request |

## Verification
Neither the enable nor the pending latch can be seen on its own. Both show only through `irq_req`. The hardest cases are the overlaps: a clear that lands in the same cycle as a new event edge, an event edge that arrives while a clear strobe is held high, and a read and a write to the enable offset that rise together. Directed sequences first set one half of the gate so that the other half becomes visible at the request output, and then hit each overlap. Seeded random traffic follows, with long strobes, chip select toggling and event bursts, and a bench model checks the request and the read claim every cycle.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    // Registered gate state: enable flop and pending latch
    typedef struct packed {
        logic en;
        logic pend;
    } gate_state_t;

    localparam gate_state_t GATE_RESET = '{en: 1'b0, pend: 1'b0};

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);

    typedef struct packed {
        logic [W-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise_o[i] = level_i[i] & ~st_q.prev[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/irq_access_dec.sv
module irq_access_dec #(
    parameter int                ADDR_W  = 4,
    parameter logic [ADDR_W-1:0] OFS_ENA = 'hB,
    parameter logic [ADDR_W-1:0] OFS_CLR = 'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              en_set_o,
    output logic              en_clr_o,
    output logic              pend_clr_o,
    output logic              rd_claim_o
);

    localparam int STB_W = 2;
    localparam int IDX_WR = 0;
    localparam int IDX_RD = 1;

    logic [STB_W-1:0] stb_lvl;
    logic [STB_W-1:0] stb_rise;
    logic             hit_ena;
    logic             hit_clr;

    assign stb_lvl[IDX_WR] = bus_cs & bus_wr;
    assign stb_lvl[IDX_RD] = bus_cs & bus_rd;

    irq_edge_det #(.W(STB_W)) u_stb_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (stb_lvl),
        .rise_o  (stb_rise)
    );

    always_comb begin
        hit_ena    = (bus_addr == OFS_ENA);
        hit_clr    = (bus_addr == OFS_CLR);
        en_set_o   = stb_rise[IDX_WR] & hit_ena;
        en_clr_o   = stb_rise[IDX_RD] & hit_ena;
        pend_clr_o = (stb_rise[IDX_WR] | stb_rise[IDX_RD]) & hit_clr;
        rd_claim_o = stb_lvl[IDX_RD] & (hit_ena | hit_clr);
    end

endmodule

// File: rtl/irq_gate_core.sv
module irq_gate_core
    import irq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_set_i,
    input  logic en_clr_i,
    input  logic pend_clr_i,
    input  logic evt_any_i,
    output logic en_o,
    output logic pend_o,
    output logic irq_o
);

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // disable has priority over enable when both rise together
        if (en_clr_i)      st_d.en = 1'b0;
        else if (en_set_i) st_d.en = 1'b1;
        // a fresh event overrides a clear in the same cycle
        if (pend_clr_i)    st_d.pend = 1'b0;
        if (evt_any_i)     st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GATE_RESET;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign irq_o  = st_q.en & st_q.pend;

endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top #(
    parameter int                ADDR_W  = 4,
    parameter int                DATA_W  = 8,
    parameter int                NUM_EVT = 3,
    parameter logic [ADDR_W-1:0] OFS_ENA = 'hB,
    parameter logic [ADDR_W-1:0] OFS_CLR = 'hF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_cs,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rd_claim,
    output logic               irq_req
);

    logic               en_set;
    logic               en_clr;
    logic               pend_clr;
    logic [NUM_EVT-1:0] evt_rise;
    logic               evt_any;
    logic               en_q;
    logic               pend_q;

    irq_access_dec #(
        .ADDR_W  (ADDR_W),
        .OFS_ENA (OFS_ENA),
        .OFS_CLR (OFS_CLR)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_cs     (bus_cs),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .en_set_o   (en_set),
        .en_clr_o   (en_clr),
        .pend_clr_o (pend_clr),
        .rd_claim_o (bus_rd_claim)
    );

    irq_edge_det #(.W(NUM_EVT)) u_evt_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (evt_in),
        .rise_o  (evt_rise)
    );

    assign evt_any = |evt_rise;

    irq_gate_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_set_i   (en_set),
        .en_clr_i   (en_clr),
        .pend_clr_i (pend_clr),
        .evt_any_i  (evt_any),
        .en_o       (en_q),
        .pend_o     (pend_q),
        .irq_o      (irq_req)
    );

    // no readable state: claimed reads return zero
    assign bus_rdata = '0;

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
    parameter int                ADDR_W  = 4,
    parameter int                DATA_W  = 8,
    parameter int                NUM_EVT = 3,
    parameter logic [ADDR_W-1:0] OFS_ENA = 'hB,
    parameter logic [ADDR_W-1:0] OFS_CLR = 'hF
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_cs,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_EVT-1:0] evt_in,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               bus_rd_claim,
    input logic               irq_req,
    input logic               en_q,
    input logic               pend_q
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !irq_req); // R1

    AST_WR_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_wr && !$past(bus_cs && bus_wr) && bus_addr == OFS_ENA
         && !(bus_cs && bus_rd && !$past(bus_cs && bus_rd))) |=> en_q); // R2

    AST_RD_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_rd && !$past(bus_cs && bus_rd) && bus_addr == OFS_ENA)
        |=> !en_q); // R3

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && (bus_rd || bus_wr) && !$past(bus_cs && (bus_rd || bus_wr))
         && bus_addr == OFS_CLR && !(|(evt_in & ~$past(evt_in)))) |=> !pend_q); // R4

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_in & ~$past(evt_in))) |=> pend_q); // R8

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !(bus_cs && bus_wr && bus_addr == OFS_ENA)) |=> !irq_req); // R6

    AST_CLAIM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_claim |-> (bus_rdata == '0 && bus_cs && bus_rd)); // R9

endmodule

bind irq_gate_top irq_gate_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_EVT (NUM_EVT),
    .OFS_ENA (OFS_ENA),
    .OFS_CLR (OFS_CLR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_cs       (bus_cs),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .evt_in       (evt_in),
    .bus_rdata    (bus_rdata),
    .bus_rd_claim (bus_rd_claim),
    .irq_req      (irq_req),
    .en_q         (en_q),
    .pend_q       (pend_q)
);

// File: tb/sim_irq_gate_top.sv
`timescale 1ns/1ps
module sim_irq_gate_top;

    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int NUM_EVT = 3;
    localparam logic [3:0] A_ENA = 4'hB;
    localparam logic [3:0] A_CLR = 4'hF;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_cs = 1'b0;
    logic               bus_rd = 1'b0;
    logic               bus_wr = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [NUM_EVT-1:0] evt_in = '0;
    logic [DATA_W-1:0]  bus_rdata;
    logic               bus_rd_claim;
    logic               irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench model state
    bit               m_en, m_pend, m_rdp, m_wrp;
    bit [NUM_EVT-1:0] m_evp;

    always #5 clk = ~clk;

    irq_gate_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .evt_in(evt_in),
        .bus_rdata(bus_rdata), .bus_rd_claim(bus_rd_claim), .irq_req(irq_req)
    );

    function automatic bit exp_claim(bit cs, bit rd, logic [3:0] a);
        return cs && rd && (a == A_ENA || a == A_CLR);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive after negedge, check combinational claim,
    // advance model at posedge, check irq before next drive
    task automatic cyc(bit cs, bit rd, bit wr, logic [3:0] a,
                       logic [NUM_EVT-1:0] ev, string tag);
        bit rd_r, wr_r, ev_r;
        @(negedge clk);
        bus_cs = cs; bus_rd = rd; bus_wr = wr; bus_addr = a; evt_in = ev;
        #1;
        check("R9", "claim", bus_rd_claim, exp_claim(cs, rd, a));
        if (bus_rd_claim) check("R9", "rdata", bus_rdata, 0);
        @(posedge clk);
        rd_r = (cs && rd) && !m_rdp;
        wr_r = (cs && wr) && !m_wrp;
        ev_r = |(ev & ~m_evp);
        if (rd_r && a == A_ENA)      m_en = 1'b0;
        else if (wr_r && a == A_ENA) m_en = 1'b1;
        if ((rd_r || wr_r) && a == A_CLR) m_pend = 1'b0;
        if (ev_r) m_pend = 1'b1;
        m_rdp = cs && rd; m_wrp = cs && wr; m_evp = ev;
        #1;
        check(tag, "irq_req", irq_req, m_en && m_pend);
    endtask

    task automatic idle(int n, logic [NUM_EVT-1:0] ev, string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 4'h0, ev, tag);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        check("R1", "irq_req in reset", irq_req, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2, '0, "R1");

        // event with enable off stays hidden, then enabling exposes it
        cyc(0, 0, 0, 4'h0, 3'b001, "R6");
        idle(1, 3'b001, "R6");
        cyc(1, 0, 1, A_ENA, 3'b000, "R2");
        idle(1, '0, "R2");
        cyc(1, 1, 0, A_ENA, '0, "R3");
        idle(1, '0, "R3");
        cyc(1, 0, 1, A_ENA, '0, "R2");
        idle(1, '0, "R6");
        cyc(1, 0, 1, A_CLR, '0, "R4");
        idle(1, '0, "R4");
        // read form of clear
        cyc(0, 0, 0, 4'h0, 3'b100, "R5");
        cyc(1, 1, 0, A_CLR, 3'b100, "R4");
        idle(1, 3'b100, "R4");
        // level held high does not re-arm after clear
        idle(3, 3'b100, "R5");
        idle(1, 3'b000, "R5");
        // long clear strobe, new event mid-strobe survives
        cyc(1, 1, 0, A_CLR, '0, "R7");
        cyc(1, 1, 0, A_CLR, 3'b010, "R7");
        cyc(1, 1, 0, A_CLR, 3'b010, "R7");
        cyc(1, 1, 0, A_CLR, 3'b010, "R7");
        idle(1, '0, "R7");
        // clear and event in the same cycle
        cyc(1, 0, 1, A_CLR, 3'b001, "R8");
        idle(1, 3'b001, "R8");
        idle(1, '0, "R8");
        // deselected and off-offset accesses have no effect
        cyc(0, 1, 0, A_ENA, '0, "R10");
        idle(1, '0, "R10");
        cyc(1, 1, 0, 4'hA, '0, "R10");
        cyc(1, 0, 1, 4'h3, '0, "R10");
        idle(1, '0, "R10");
        cyc(1, 1, 0, A_ENA, '0, "R3");
        idle(1, '0, "R3");
        cyc(0, 0, 1, A_ENA, '0, "R10");
        idle(1, '0, "R10");
        // long write strobe to enable only once; held read then cannot re-fire
        cyc(1, 0, 1, A_ENA, '0, "R7");
        cyc(1, 0, 1, A_ENA, '0, "R7");
        cyc(1, 1, 1, A_ENA, '0, "R11");
        idle(1, '0, "R11");
        // simultaneous rising read and write at the enable offset
        cyc(1, 0, 1, A_ENA, '0, "R2");
        idle(1, '0, "R2");
        cyc(1, 1, 1, A_ENA, '0, "R11");
        idle(1, '0, "R11");
        // claim decoding at other offsets
        cyc(1, 1, 0, 4'h7, '0, "R9");
        cyc(1, 1, 0, A_CLR, '0, "R9");
        idle(1, '0, "R9");

        // seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom_range(0, 9);
            logic [3:0] a = (sel < 4) ? A_ENA : (sel < 7) ? A_CLR : 4'($urandom_range(0, 15));
            bit cs = ($urandom_range(0, 7) != 0);
            bit rd = ($urandom_range(0, 2) == 0);
            bit wr = ($urandom_range(0, 2) == 0);
            logic [NUM_EVT-1:0] ev = ($urandom_range(0, 3) == 0) ? NUM_EVT'($urandom) : evt_in;
            cyc(cs, rd, wr, a, ev, "R6");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule